// File: doc/BRIEF.md
# Data-Processing Execute Unit

This block is the execute stage for the register-to-register arithmetic and logic class of a 32-bit instruction word. Each cycle it decodes the word and sends the two source register indices to a combinational register-file read port. It builds the second operand either from a register shifted by a constant amount or from a small immediate rotated into place. It then runs one of sixteen operations and presents a destination write (enable, index, data) in the same cycle.

The unit holds the four condition flags (negative, zero, carry, overflow) in an internal register and shows them on its output. An instruction takes effect only while `in_valid` is high. The flags change on the clock edge that ends the instruction, and only for instructions that ask for it. Words whose class bits do not match are ignored. Condition evaluation, memory access and register-amount shifts are handled elsewhere.

Top module: `dp_exec_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears the flag register to 0000. `flags_q` bit 3 is N, bit 2 is Z, bit 1 is C and bit 0 is V.
- R2: A word belongs to this class when bits 27:26 are 00. Rn is bits 19:16 and goes out on `rn_addr`. Rm is bits 3:0 and goes out on `rm_addr`. Rd is bits 15:12 and goes out on `wr_addr`. The opcode is bits 24:21 and the set-flags bit S is bit 20.
- R3: The logical opcodes write Rd as follows: 0000 Rn AND op2, 0001 Rn XOR op2, 1100 Rn OR op2, 1101 op2, 1110 Rn AND NOT op2, 1111 NOT op2.
- R4: The arithmetic opcodes write Rd as follows: 0010 Rn-op2, 0011 op2-Rn, 0100 Rn+op2, 0101 Rn+op2+C, 0110 Rn-op2-(1-C), 0111 op2-Rn-(1-C). C is the current carry flag.
- R5: Opcodes 1000 (AND), 1001 (XOR), 1010 (subtract Rn-op2) and 1011 (add Rn+op2) never assert `wr_en`. They update the flags from their result even when S is 0.
- R6: For the other opcodes the flags are loaded only when S (bit 20) is 1. When S is 0 they keep their value.
- R7: After an arithmetic opcode, N is result bit 31 and Z is 1 when the result is zero. C is the adder carry-out, which for subtraction is 1 when no borrow occurs. V is 1 on signed overflow.
- R8: After a logical opcode, N and Z come from the result and C is the shifter carry-out defined in R9/R10. V keeps its previous value.
- R9: When bit 25 is 1, op2 is bits 7:0 zero-extended and rotated right by twice bits 11:8. The shifter carry is result bit 31 when the rotation is non-zero, and the current C otherwise.
- R10: When bit 25 is 0, op2 is Rm shifted by the amount in bits 11:7, using the type in bits 6:5 (00 shift left, 01 logical shift right, 10 arithmetic shift right, 11 rotate right). Bit 4 is ignored. An amount of 0 passes Rm unchanged with the current C as carry. Any other amount gives the last bit shifted out as carry.
- R11: When `in_valid` is low, or when bits 27:26 are not 00, `wr_en` stays low and the flags are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | The instruction word is valid this cycle |
| instr | input | 32 | Instruction word |
| rn_addr | output | 4 | First-operand register index |
| rm_addr | output | 4 | Second-operand register index |
| rn_data | input | 32 | Read data for `rn_addr` |
| rm_data | input | 32 | Read data for `rm_addr` |
| wr_en | output | 1 | Destination write enable |
| wr_addr | output | 4 | Destination register index |
| wr_data | output | 32 | Destination write data |
| flags_q | output | 4 | Flag register {N,Z,C,V} |

## Verification
Directed words cover the corner cases of each operation. Signed and unsigned boundary sums separate the carry from the overflow flag. Subtractions with the carry flag both set and clear show whether the borrow is applied as the inverse of C. Each shift type is applied to an operand with bit 31 set, so the shift types give different results, and a zero shift amount is paired with bit 4 set. Test-only opcodes with S clear, plain opcodes with S clear, invalid cycles and foreign class bits show whether the write and the flag update are gated apart. A long stream of pseudo-random words, with the operand registers and the flags carried over between them, then checks every opcode against an independent model that works in 64-bit integers.

// File: rtl/dp_exec_pkg.sv
package dp_exec_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'h0, OP_EOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
    OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
    OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
    OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
  } dp_op_e;

  typedef enum logic [1:0] {
    SH_LSL = 2'd0, SH_LSR = 2'd1, SH_ASR = 2'd2, SH_ROR = 2'd3
  } shift_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  // Test-only group: compare and test opcodes, no writeback
  function automatic logic op_is_test(dp_op_e op);
    return op[3:2] == 2'b10;
  endfunction

  // Opcodes whose carry comes from the shifter rather than the adder
  function automatic logic op_is_logical(dp_op_e op);
    return op inside {OP_AND, OP_EOR, OP_TST, OP_TEQ, OP_ORR, OP_MOV, OP_BIC, OP_MVN};
  endfunction

endpackage

// File: rtl/dp_operand2.sv
module dp_operand2
  import dp_exec_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [11:0]   op2_field,
  input  logic          imm_sel,
  input  logic [DW-1:0] rm_data,
  input  logic          c_in,
  output logic [DW-1:0] op2,
  output logic          sh_carry
);
  localparam int SHF = 5;   // width of both shift amount and doubled rotate
  localparam int IMW = 8;

  function automatic logic [DW-1:0] ror_f(logic [DW-1:0] x, logic [SHF-1:0] n);
    return (x >> n) | (x << (DW - int'(n)));
  endfunction

  // Immediate path
  logic [SHF-1:0] rot_amt;
  logic [DW-1:0]  imm_val;
  logic           imm_c;
  assign rot_amt = {op2_field[11:8], 1'b0};
  assign imm_val = ror_f(DW'(op2_field[IMW-1:0]), rot_amt);
  assign imm_c   = (rot_amt == '0) ? c_in : imm_val[DW-1];

  // Register path, constant amount
  logic [SHF-1:0] sh_amt;
  shift_e         sh_type;
  logic [DW-1:0]  sh_val;
  logic           sh_c;
  logic           unused_regshift_bit;
  assign sh_amt  = op2_field[11:7];
  assign sh_type = shift_e'(op2_field[6:5]);
  assign unused_regshift_bit = op2_field[4];

  always_comb begin
    sh_val = rm_data;
    sh_c   = c_in;
    if (sh_amt != '0) begin
      case (sh_type)
        SH_LSL:  {sh_c, sh_val} = {1'b0, rm_data} << sh_amt;
        SH_LSR:  {sh_val, sh_c} = {rm_data, 1'b0} >> sh_amt;
        SH_ASR:  {sh_val, sh_c} = $signed({rm_data, 1'b0}) >>> sh_amt;
        default: begin
          sh_val = ror_f(rm_data, sh_amt);
          sh_c   = sh_val[DW-1];
        end
      endcase
    end
  end

  assign op2      = imm_sel ? imm_val : sh_val;
  assign sh_carry = imm_sel ? imm_c : sh_c;

  AST_IMM_NO_ROTATE: assert property (@(posedge clk) disable iff (rst)
    (imm_sel && op2_field[11:8] == 4'h0) |-> (op2 == DW'(op2_field[7:0]) && sh_carry == c_in))
    else $error("immediate without rotation altered"); // R9
  AST_ZERO_SHIFT_PASS: assert property (@(posedge clk) disable iff (rst)
    (!imm_sel && op2_field[11:7] == 5'd0) |-> (op2 == rm_data && sh_carry == c_in))
    else $error("zero shift altered operand"); // R10
endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_exec_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  dp_op_e        op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          c_in,
  input  logic          v_in,
  input  logic          sh_c,
  output logic [DW-1:0] res,
  output flags_t        flags_out
);
  function automatic logic [DW:0] add_f(logic [DW-1:0] x, logic [DW-1:0] y, logic ci);
    return {1'b0, x} + {1'b0, y} + {{DW{1'b0}}, ci};
  endfunction

  function automatic logic ovf_f(logic [DW-1:0] x, logic [DW-1:0] y, logic [DW-1:0] s);
    return (x[DW-1] == y[DW-1]) && (s[DW-1] != x[DW-1]);
  endfunction

  logic [DW-1:0] ax, ay;
  logic          aci;
  logic [DW:0]   sum;
  logic          is_log;

  // One adder: subtraction as x + ~y + carry-in
  always_comb begin
    ax  = a;
    ay  = b;
    aci = 1'b0;
    case (op)
      OP_SUB, OP_CMP: begin ay = ~b; aci = 1'b1; end
      OP_RSB:         begin ax = b; ay = ~a; aci = 1'b1; end
      OP_ADC:         aci = c_in;
      OP_SBC:         begin ay = ~b; aci = c_in; end
      OP_RSC:         begin ax = b; ay = ~a; aci = c_in; end
      default:        ;
    endcase
  end

  assign sum    = add_f(ax, ay, aci);
  assign is_log = op_is_logical(op);

  always_comb begin
    case (op)
      OP_AND, OP_TST: res = a & b;
      OP_EOR, OP_TEQ: res = a ^ b;
      OP_ORR:         res = a | b;
      OP_MOV:         res = b;
      OP_BIC:         res = a & ~b;
      OP_MVN:         res = ~b;
      default:        res = sum[DW-1:0];
    endcase
  end

  assign flags_out.n = res[DW-1];
  assign flags_out.z = (res == '0);
  assign flags_out.c = is_log ? sh_c : sum[DW];
  assign flags_out.v = is_log ? v_in : ovf_f(ax, ay, sum[DW-1:0]);

  AST_MOV_PASSES_OP2: assert property (@(posedge clk) disable iff (rst)
    (op == OP_MOV) |-> (res == b)) else $error("move result differs from op2"); // R3
  AST_ADD_CARRY_WRAPS: assert property (@(posedge clk) disable iff (rst)
    (op == OP_ADD && flags_out.c) |-> (res < a)) else $error("add carry without wrap"); // R7
  AST_SUB_NOBORROW: assert property (@(posedge clk) disable iff (rst)
    (op == OP_SUB) |-> (flags_out.c == (a >= b))) else $error("subtract carry wrong"); // R7
endmodule

// File: rtl/dp_exec_unit.sv
module dp_exec_unit
  import dp_exec_pkg::*;
#(
  parameter int DW = 32,
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [31:0]   instr,
  output logic [RW-1:0] rn_addr,
  output logic [RW-1:0] rm_addr,
  input  logic [DW-1:0] rn_data,
  input  logic [DW-1:0] rm_data,
  output logic          wr_en,
  output logic [RW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic [3:0]    flags_q
);
  localparam int FW = $bits(flags_t);

  // Field decode
  logic   is_dp, imm_sel, s_bit, test_op, flag_upd;
  dp_op_e op;
  logic [3:0] unused_cond;
  assign unused_cond = instr[31:28];
  assign is_dp   = (instr[27:26] == 2'b00);
  assign imm_sel = instr[25];
  assign op      = dp_op_e'(instr[24:21]);
  assign s_bit   = instr[20];
  assign rn_addr = instr[16 +: RW];
  assign wr_addr = instr[12 +: RW];
  assign rm_addr = instr[0 +: RW];
  assign test_op = op_is_test(op);

  flags_t        flags_r, flags_nx;
  logic [DW-1:0] op2;
  logic          sh_c;

  dp_operand2 #(.DW(DW)) u_op2 (
    .clk      (clk),
    .rst      (rst),
    .op2_field(instr[11:0]),
    .imm_sel  (imm_sel),
    .rm_data  (rm_data),
    .c_in     (flags_r.c),
    .op2      (op2),
    .sh_carry (sh_c)
  );

  dp_alu #(.DW(DW)) u_alu (
    .clk      (clk),
    .rst      (rst),
    .op       (op),
    .a        (rn_data),
    .b        (op2),
    .c_in     (flags_r.c),
    .v_in     (flags_r.v),
    .sh_c     (sh_c),
    .res      (wr_data),
    .flags_out(flags_nx)
  );

  assign wr_en    = in_valid && is_dp && !test_op;
  assign flag_upd = in_valid && is_dp && (s_bit || test_op);

  always_ff @(posedge clk) begin
    if (rst)           flags_r <= '0;
    else if (flag_upd) flags_r <= flags_nx;
  end

  assign flags_q = FW'(flags_r);

  AST_RESET_CLEARS_FLAGS: assert property (@(posedge clk)
    rst |=> (flags_q == 4'h0)) else $error("flags not cleared"); // R1
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !flag_upd |=> $stable(flags_q)) else $error("flags moved without update"); // R6
  AST_FLAGS_LOAD: assert property (@(posedge clk) disable iff (rst)
    flag_upd |=> (flags_q == $past(flags_nx))) else $error("flags not loaded"); // R7
  AST_TEST_NO_WB: assert property (@(posedge clk) disable iff (rst)
    (in_valid && test_op) |-> !wr_en) else $error("test opcode wrote back"); // R5
  AST_INVALID_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!in_valid || !is_dp) |-> (!wr_en && !flag_upd)) else $error("idle cycle acted"); // R11
endmodule

// File: tb/dp_exec_unit_tb.sv
module dp_exec_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] instr;
  logic [3:0]  rn_addr, rm_addr, wr_addr;
  logic [31:0] rn_data, rm_data, wr_data;
  logic        wr_en;
  logic [3:0]  flags_q;
  logic [31:0] regs [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign rn_data = regs[rn_addr];
  assign rm_data = regs[rm_addr];

  dp_exec_unit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
    .rn_addr(rn_addr), .rm_addr(rm_addr), .rn_data(rn_data), .rm_data(rm_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .flags_q(flags_q)
  );

  typedef struct packed {
    logic [31:0] tag;
    logic        we;
    logic [3:0]  wa;
    logic [31:0] wd;
    logic [3:0]  fl;
  } exp_t;

  exp_t        sb_q[$];
  logic [3:0]  mflags;
  int          n_checks = 0;
  int          n_errors = 0;

  task automatic chk(logic [31:0] tag, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  // Independent reference: 64-bit integer arithmetic, bitwise rotation loop
  function automatic exp_t model(logic [31:0] ins, logic vld, logic [31:0] a,
                                 logic [31:0] m, logic [3:0] f);
    exp_t e;
    logic [31:0] b, r;
    logic sc, cf, n, z, c, v, dp, tst, lg;
    logic [3:0] op;
    logic [4:0] amt;
    longint ua, ub, ci, sa, sb, ur, sr;
    cf = f[1];
    if (ins[25]) begin
      b = {24'd0, ins[7:0]};
      for (int k = 0; k < 2 * int'(ins[11:8]); k++) b = {b[0], b[31:1]};
      sc = (ins[11:8] == 4'd0) ? cf : b[31];
    end else begin
      amt = ins[11:7];
      b = m; sc = cf;
      if (amt != 0) begin
        case (ins[6:5])
          2'd0: begin b = m << amt; sc = m[32 - int'(amt)]; end
          2'd1: begin b = m >> amt; sc = m[int'(amt) - 1]; end
          2'd2: begin b = $signed(m) >>> amt; sc = m[int'(amt) - 1]; end
          default: begin b = 32'({m, m} >> amt); sc = b[31]; end
        endcase
      end
    end
    op = ins[24:21];
    ua = longint'(a); ub = longint'(b); ci = cf ? 1 : 0;
    sa = longint'($signed(a)); sb = longint'($signed(b));
    ur = 0; sr = 0; c = 1'b0;
    lg = 1'b0;
    case (op)
      4'h2, 4'hA: begin ur = ua - ub; sr = sa - sb; c = (ua >= ub); end
      4'h3: begin ur = ub - ua; sr = sb - sa; c = (ub >= ua); end
      4'h4, 4'hB: begin ur = ua + ub; sr = sa + sb; c = (ur > 64'hFFFF_FFFF); end
      4'h5: begin ur = ua + ub + ci; sr = sa + sb + ci; c = (ur > 64'hFFFF_FFFF); end
      4'h6: begin ur = ua - ub - (1 - ci); sr = sa - sb - (1 - ci); c = (ua >= ub + 1 - ci); end
      4'h7: begin ur = ub - ua - (1 - ci); sr = sb - sa - (1 - ci); c = (ub >= ua + 1 - ci); end
      default: lg = 1'b1;
    endcase
    case (op)
      4'h0, 4'h8: r = a & b;
      4'h1, 4'h9: r = a ^ b;
      4'hC: r = a | b;
      4'hD: r = b;
      4'hE: r = a & ~b;
      4'hF: r = ~b;
      default: r = ur[31:0];
    endcase
    n = r[31];
    z = (r == 32'd0);
    if (lg) begin c = sc; v = f[0]; end
    else v = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
    dp  = (ins[27:26] == 2'b00);
    tst = (op >= 4'h8 && op <= 4'hB);
    e.tag = 32'd0;
    e.we  = vld && dp && !tst;
    e.wa  = ins[15:12];
    e.wd  = r;
    e.fl  = (vld && dp && (ins[20] || tst)) ? {n, z, c, v} : f;
    return e;
  endfunction

  function automatic logic [31:0] mk(logic i, logic [3:0] op, logic s, logic [3:0] rn,
                                     logic [3:0] rd, logic [11:0] o2);
    return {4'hE, 2'b00, i, op, s, rn, rd, o2};
  endfunction

  function automatic logic [11:0] rsh(logic [4:0] amt, logic [1:0] ty, logic [3:0] rm);
    return {amt, ty, 1'b0, rm};
  endfunction

  // Driver: applies one word and pushes its expected outcome
  task automatic drive(logic [31:0] tag, logic [31:0] ins, logic vld,
                       logic [31:0] av, logic [31:0] mv);
    exp_t e;
    @(negedge clk);
    regs[ins[19:16]] = av;
    regs[ins[3:0]]   = mv;
    instr    = ins;
    in_valid = vld;
    e = model(ins, vld, regs[ins[19:16]], regs[ins[3:0]], mflags);
    e.tag = tag;
    mflags = e.fl;
    sb_q.push_back(e);
  endtask

  task automatic do_reset();
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    mflags = 4'h0;
    #(CLK_PERIOD/4);
    chk("R1", "flags after reset", 32'(flags_q), 32'h0);
  endtask

  // Monitor: pops each expected item and compares outputs, then the flags
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (sb_q.size() > 0) begin
        e = sb_q.pop_front();
        chk(e.tag, "wr_en", 32'(wr_en), 32'(e.we));
        if (e.we) begin
          chk(e.tag, "wr_addr", 32'(wr_addr), 32'(e.wa));
          chk(e.tag, "wr_data", wr_data, e.wd);
        end
        @(posedge clk);
        #1;
        chk(e.tag, "flags", 32'(flags_q), 32'(e.fl));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] ins;
    rst = 1'b1; in_valid = 1'b0; instr = '0; mflags = 4'h0;
    for (int i = 0; i < 16; i++) regs[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #(CLK_PERIOD/4);
    chk("R1", "flags after reset", 32'(flags_q), 32'h0);

    // R9 immediates: no rotation, rotation by 2, rotation wrapping
    drive("R9", mk(1, 4'hD, 1, 4'd0, 4'd1, {4'd0, 8'hFF}), 1, 0, 0);
    drive("R9", mk(1, 4'hD, 1, 4'd0, 4'd2, {4'd1, 8'h03}), 1, 0, 0);
    drive("R9", mk(1, 4'hC, 1, 4'd3, 4'd4, {4'd12, 8'hA5}), 1, 32'h1, 0);
    // R4 / R7 arithmetic and flags
    drive("R7", mk(0, 4'h4, 1, 4'd1, 4'd5, rsh(0, 0, 4'd2)), 1, 32'h7FFF_FFFF, 32'h1);
    drive("R7", mk(0, 4'h4, 1, 4'd1, 4'd5, rsh(0, 0, 4'd2)), 1, 32'hFFFF_FFFF, 32'h1);
    drive("R4", mk(0, 4'h5, 1, 4'd1, 4'd6, rsh(0, 0, 4'd2)), 1, 32'd5, 32'd3);
    drive("R7", mk(0, 4'h2, 1, 4'd1, 4'd7, rsh(0, 0, 4'd2)), 1, 32'd3, 32'd5);
    drive("R4", mk(0, 4'h6, 1, 4'd1, 4'd7, rsh(0, 0, 4'd2)), 1, 32'd10, 32'd3);
    drive("R4", mk(0, 4'h3, 1, 4'd1, 4'd8, rsh(0, 0, 4'd2)), 1, 32'd4, 32'd9);
    drive("R4", mk(0, 4'h7, 1, 4'd1, 4'd8, rsh(0, 0, 4'd2)), 1, 32'd4, 32'd9);
    drive("R7", mk(0, 4'h2, 1, 4'd1, 4'd9, rsh(0, 0, 4'd2)), 1, 32'h8000_0000, 32'h1);
    // R10 shift types with bit 31 set, and zero amount with bit 4 set
    drive("R10", mk(0, 4'hD, 1, 4'd0, 4'd3, rsh(5'd4, 2'd0, 4'd2)), 1, 0, 32'hF000_000F);
    drive("R10", mk(0, 4'hD, 1, 4'd0, 4'd3, rsh(5'd1, 2'd1, 4'd2)), 1, 0, 32'h8000_0001);
    drive("R10", mk(0, 4'hD, 1, 4'd0, 4'd3, rsh(5'd8, 2'd2, 4'd2)), 1, 0, 32'h8000_0080);
    drive("R10", mk(0, 4'hD, 1, 4'd0, 4'd3, rsh(5'd8, 2'd3, 4'd2)), 1, 0, 32'h8000_0012);
    drive("R10", mk(0, 4'hD, 1, 4'd0, 4'd3, 12'h01_2), 1, 0, 32'h1234_5678);
    // R3 / R8 logical ops, V held and C from shifter
    drive("R3", mk(0, 4'h0, 1, 4'd1, 4'd10, rsh(5'd1, 2'd1, 4'd2)), 1, 32'hFFFF_00FF, 32'h0000_0F01);
    drive("R3", mk(0, 4'h1, 0, 4'd1, 4'd10, rsh(0, 0, 4'd2)), 1, 32'hAAAA_5555, 32'hFFFF_0000);
    drive("R3", mk(0, 4'hC, 0, 4'd1, 4'd10, rsh(0, 0, 4'd2)), 1, 32'h0F00_0000, 32'h0000_00F0);
    drive("R3", mk(0, 4'hE, 1, 4'd1, 4'd10, rsh(0, 0, 4'd2)), 1, 32'hFFFF_FFFF, 32'h0000_FFFF);
    drive("R3", mk(0, 4'hF, 1, 4'd1, 4'd10, rsh(0, 0, 4'd2)), 1, 0, 32'hFFFF_FFFF);
    drive("R8", mk(0, 4'h4, 1, 4'd1, 4'd5, rsh(0, 0, 4'd2)), 1, 32'h7FFF_FFFF, 32'h1);
    drive("R8", mk(0, 4'h0, 1, 4'd1, 4'd10, rsh(5'd1, 2'd0, 4'd2)), 1, 32'hFFFF_FFFF, 32'h8000_0000);
    // R5 test-only opcodes with S clear
    drive("R5", mk(0, 4'h8, 0, 4'd1, 4'd11, rsh(0, 0, 4'd2)), 1, 32'hF0, 32'h0F);
    drive("R5", mk(0, 4'h9, 0, 4'd1, 4'd11, rsh(0, 0, 4'd2)), 1, 32'h8000_0000, 32'h1);
    drive("R5", mk(0, 4'hA, 0, 4'd1, 4'd11, rsh(0, 0, 4'd2)), 1, 32'd7, 32'd7);
    drive("R5", mk(0, 4'hB, 0, 4'd1, 4'd11, rsh(0, 0, 4'd2)), 1, 32'hFFFF_FFFF, 32'h1);
    // R6 S clear keeps flags
    drive("R6", mk(0, 4'h2, 0, 4'd1, 4'd12, rsh(0, 0, 4'd2)), 1, 32'd1, 32'd2);
    drive("R6", mk(1, 4'hD, 0, 4'd0, 4'd12, {4'd0, 8'h00}), 1, 0, 0);
    // R11 invalid cycle and foreign class bits
    drive("R11", mk(0, 4'h2, 1, 4'd1, 4'd13, rsh(0, 0, 4'd2)), 0, 32'd1, 32'd2);
    ins = mk(0, 4'h2, 1, 4'd1, 4'd13, rsh(0, 0, 4'd2));
    ins[27:26] = 2'b01;
    drive("R11", ins, 1, 32'd1, 32'd2);
    // R2 field positions: distinct Rn, Rm, Rd; Rn and Rm sharing an index
    drive("R2", mk(0, 4'h4, 1, 4'd14, 4'd15, rsh(0, 0, 4'd3)), 1, 32'd100, 32'd23);
    drive("R2", mk(0, 4'h4, 1, 4'd6, 4'd0, rsh(0, 0, 4'd6)), 1, 32'd11, 32'd11);
    // R1 reset from non-zero flags
    drive("R5", mk(0, 4'hB, 0, 4'd1, 4'd0, rsh(0, 0, 4'd2)), 1, 32'hFFFF_FFFF, 32'h1);
    do_reset();
    // R2 pseudo-random stream
    for (int t = 0; t < 400; t++) begin
      ins = $urandom();
      ins[27:26] = ($urandom() % 8 == 0) ? 2'b01 : 2'b00;
      drive("R2", ins, ($urandom() % 10) != 0, $urandom(), $urandom());
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule